// File: doc/BRIEF.md
# Low Register Add/Sub/Compare Unit

This unit performs the arithmetic of the short instruction encodings that work on the eight low registers, and it produces the four condition flags: negative, zero, carry and overflow. The decoder has already split out the instruction fields, and the register file has already read the operand values. Both arrive at the unit together with the current flags. One clock later the unit returns the result, a write enable, the destination index and the new flags.

A format-select input picks the encoding group. The three-operand group adds or subtracts a second operand from a register value. That second operand is either a small 3-bit immediate or a second register. The immediate group has a 2-bit operation code. It moves, compares, adds or subtracts an 8-bit zero-extended immediate against one register. A compare updates the flags but does not write back. A move of an immediate changes only the negative and zero flags.

Top module: `lowreg_alu`

## Requirements
- R1: While `rst` is high, at every clock edge `out_valid`, `wr_en`, `result`, `wr_idx` and `flags_out` clear to zero.
- R2: When `fmt_sel`=0 and `imm_sel`=1, the second operand is `fld3` zero-extended and `opb` is ignored. When `imm_sel`=0, the second operand is `opb`.
- R3: On an addition, the result is op1+op2 modulo 2^32. C is the unsigned carry out of bit 31. V is bit 31 of ((op1 XOR result) AND (op2 XOR result)).
- R4: On a subtraction, the result is op1-op2 modulo 2^32. C is 1 exactly when op2 <= op1 as unsigned numbers. V is bit 31 of ((op1 XOR result) AND ((NOT op2) XOR result)).
- R5: When `fmt_sel`=1, `imm_op` selects the operation: 00 move, 01 compare, 10 add, 11 subtract. op1 is `opa`, op2 is `imm8` zero-extended, and `opb`, `sub_sel` and `imm_sel` are ignored.
- R6: A compare sets all four flags from op1-op2. It reports the difference on `result` and holds `wr_en` low.
- R7: A move of an immediate returns the zero-extended `imm8` with `wr_en` high. It sets N and Z from that value and copies C and V from `flags_in`.
- R8: For every operation, N equals bit 31 of the result and Z is 1 exactly when the result is zero. `flags_out` is packed as {N,Z,C,V}, with N in bit 3.
- R9: An operation accepted with `in_valid` high appears on the outputs after exactly one clock edge, with `out_valid` high and `wr_idx` equal to the `dst_idx` that was presented. In the three-operand group `wr_en` is always 1.
- R10: After an edge where `in_valid` is low, `out_valid` and `wr_en` are 0, while `result`, `flags_out` and `wr_idx` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| fmt_sel | input | 1 | 0 = three-operand group, 1 = immediate group |
| sub_sel | input | 1 | Three-operand group: 1 = subtract, 0 = add |
| imm_sel | input | 1 | Three-operand group: second operand is `fld3` rather than `opb` |
| fld3 | input | 3 | 3-bit immediate field |
| imm_op | input | 2 | Immediate-group operation code |
| imm8 | input | 8 | 8-bit immediate |
| dst_idx | input | 3 | Destination register index |
| opa | input | 32 | First operand value |
| opb | input | 32 | Register value selected by the 3-bit field |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Write the result to the destination |
| wr_idx | output | 3 | Destination index |
| flags_out | output | 4 | New flags {N,Z,C,V} |

## Verification
The vector table first covers additions that do and do not carry out of bit 31, and one that overflows in the signed sense. These cases separate C from V. Subtractions are run with op2 above, equal to and below op1, plus one signed overflow, so that the borrow sense of C and the equality case of Z are each pinned down. In the immediate group, moves are run with different incoming C/V values and one zero immediate, and compares are run with equal and unequal operands, so the kept flags and the suppressed write are each observed. The same vectors also drive a deliberately poisoned `opb` wherever that value must be ignored. Directed steps then cover reset, idle hold and a reset in the middle of a stream.

// File: rtl/lowreg_pkg.sv
package lowreg_pkg;
  // flag vector layout {N,Z,C,V}
  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_C = 1;
  localparam int FL_V = 0;
  localparam int FLW  = 4;

  typedef enum logic [1:0] {
    IOP_MOVE = 2'b00,
    IOP_CMP  = 2'b01,
    IOP_ADD  = 2'b10,
    IOP_SUB  = 2'b11
  } imm_op_e;

  typedef struct packed {
    logic do_sub;
    logic do_move;
    logic do_write;
    logic keep_cv;
  } ctrl_t;
endpackage

// File: rtl/lowreg_opsel.sv
module lowreg_opsel
  import lowreg_pkg::*;
#(
  parameter int W    = 32,
  parameter int FLDW = 3,
  parameter int IMMW = 8
) (
  input  logic            fmt_sel,
  input  logic            sub_sel,
  input  logic            imm_sel,
  input  logic [FLDW-1:0] fld3,
  input  logic [1:0]      imm_op,
  input  logic [IMMW-1:0] imm8,
  input  logic [W-1:0]    opb,
  output logic [W-1:0]    op2,
  output ctrl_t           ctrl
);
  localparam int FPAD = W - FLDW;
  localparam int IPAD = W - IMMW;

  logic [W-1:0] fld_ext;
  logic [W-1:0] imm_ext;

  assign fld_ext = {{FPAD{1'b0}}, fld3};
  assign imm_ext = {{IPAD{1'b0}}, imm8};

  always_comb begin
    if (!fmt_sel) begin
      op2           = imm_sel ? fld_ext : opb;
      ctrl.do_sub   = sub_sel;
      ctrl.do_move  = 1'b0;
      ctrl.do_write = 1'b1;
      ctrl.keep_cv  = 1'b0;
    end else begin
      op2 = imm_ext;
      unique case (imm_op_e'(imm_op))
        IOP_MOVE: begin
          ctrl.do_sub = 1'b0; ctrl.do_move = 1'b1;
          ctrl.do_write = 1'b1; ctrl.keep_cv = 1'b1;
        end
        IOP_CMP: begin
          ctrl.do_sub = 1'b1; ctrl.do_move = 1'b0;
          ctrl.do_write = 1'b0; ctrl.keep_cv = 1'b0;
        end
        IOP_ADD: begin
          ctrl.do_sub = 1'b0; ctrl.do_move = 1'b0;
          ctrl.do_write = 1'b1; ctrl.keep_cv = 1'b0;
        end
        default: begin
          ctrl.do_sub = 1'b1; ctrl.do_move = 1'b0;
          ctrl.do_write = 1'b1; ctrl.keep_cv = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/lowreg_addsub.sv
module lowreg_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] op1,
  input  logic [W-1:0] op2,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  logic [W-1:0] op2_eff;
  logic [W:0]   wide;

  // subtraction as op1 + ~op2 + 1; carry out then means "no borrow"
  assign op2_eff = do_sub ? ~op2 : op2;
  assign wide    = {1'b0, op1} + {1'b0, op2_eff} + {{W{1'b0}}, do_sub};
  assign sum     = wide[W-1:0];
  assign carry   = wide[W];
  assign ovf     = (op1[W-1] ^ sum[W-1]) & (op2_eff[W-1] ^ sum[W-1]);
endmodule

// File: rtl/lowreg_flags.sv
module lowreg_flags
  import lowreg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]   res,
  input  logic           carry,
  input  logic           ovf,
  input  logic           keep_cv,
  input  logic [FLW-1:0] flags_in,
  output logic [FLW-1:0] flags_nx
);
  always_comb begin
    flags_nx[FL_N] = res[W-1];
    flags_nx[FL_Z] = (res == '0);
    flags_nx[FL_C] = keep_cv ? flags_in[FL_C] : carry;
    flags_nx[FL_V] = keep_cv ? flags_in[FL_V] : ovf;
  end
endmodule

// File: rtl/lowreg_alu.sv
module lowreg_alu
  import lowreg_pkg::*;
#(
  parameter int W    = 32,
  parameter int FLDW = 3,
  parameter int IMMW = 8,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            fmt_sel,
  input  logic            sub_sel,
  input  logic            imm_sel,
  input  logic [FLDW-1:0] fld3,
  input  logic [1:0]      imm_op,
  input  logic [IMMW-1:0] imm8,
  input  logic [IDXW-1:0] dst_idx,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic [3:0]      flags_in,
  output logic            out_valid,
  output logic [W-1:0]    result,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [3:0]      flags_out
);
  logic [W-1:0]   op2;
  ctrl_t          ctrl;
  logic [W-1:0]   sum;
  logic           carry;
  logic           ovf;
  logic [W-1:0]   res_nx;
  logic [FLW-1:0] flags_nx;

  lowreg_opsel #(.W(W), .FLDW(FLDW), .IMMW(IMMW)) u_opsel (
    .fmt_sel(fmt_sel), .sub_sel(sub_sel), .imm_sel(imm_sel),
    .fld3(fld3), .imm_op(imm_op), .imm8(imm8), .opb(opb),
    .op2(op2), .ctrl(ctrl)
  );

  lowreg_addsub #(.W(W)) u_addsub (
    .op1(opa), .op2(op2), .do_sub(ctrl.do_sub),
    .sum(sum), .carry(carry), .ovf(ovf)
  );

  assign res_nx = ctrl.do_move ? op2 : sum;

  lowreg_flags #(.W(W)) u_flags (
    .res(res_nx), .carry(carry), .ovf(ovf), .keep_cv(ctrl.keep_cv),
    .flags_in(flags_in), .flags_nx(flags_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      result    <= '0;
      wr_idx    <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid & ctrl.do_write;
      if (in_valid) begin
        result    <= res_nx;
        wr_idx    <= dst_idx;
        flags_out <= flags_nx;
      end
    end
  end
endmodule

// File: rtl/lowreg_alu_chk.sv
module lowreg_alu_chk #(
  parameter int W    = 32,
  parameter int FLDW = 3,
  parameter int IMMW = 8,
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            fmt_sel,
  input logic            sub_sel,
  input logic            imm_sel,
  input logic [1:0]      imm_op,
  input logic [IMMW-1:0] imm8,
  input logic [IDXW-1:0] dst_idx,
  input logic [W-1:0]    opa,
  input logic [W-1:0]    opb,
  input logic [3:0]      flags_in,
  input logic            out_valid,
  input logic [W-1:0]    result,
  input logic            wr_en,
  input logic [IDXW-1:0] wr_idx,
  input logic [3:0]      flags_out
);
  localparam int IPAD = W - IMMW;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !wr_en && result == '0 && flags_out == 4'd0));

  assert_sub_carry_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !fmt_sel && sub_sel && !imm_sel)
      |=> flags_out[1] == ($past(opb) <= $past(opa)));

  assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fmt_sel && imm_op == 2'b01) |=> (out_valid && !wr_en));

  assert_move_keeps_cv_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fmt_sel && imm_op == 2'b00)
      |=> (flags_out[1:0] == $past(flags_in[1:0]) && wr_en
           && result == {{IPAD{1'b0}}, $past(imm8)}));

  assert_nz_track_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flags_out[3] == result[W-1] && flags_out[2] == (result == '0)));

  assert_dest_echo_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid && wr_idx == $past(dst_idx)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !$past(rst)) |=> (!out_valid && !wr_en && $stable(result) && $stable(flags_out)));
endmodule

bind lowreg_alu lowreg_alu_chk #(.W(W), .FLDW(FLDW), .IMMW(IMMW), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .fmt_sel(fmt_sel),
  .sub_sel(sub_sel), .imm_sel(imm_sel), .imm_op(imm_op), .imm8(imm8),
  .dst_idx(dst_idx), .opa(opa), .opb(opb), .flags_in(flags_in),
  .out_valid(out_valid), .result(result), .wr_en(wr_en),
  .wr_idx(wr_idx), .flags_out(flags_out)
);

// File: tb/sim_lowreg_alu.sv
`timescale 1ns/1ps
module sim_lowreg_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        fmt_sel = 1'b0, sub_sel = 1'b0, imm_sel = 1'b0;
  logic [2:0]  fld3 = '0;
  logic [1:0]  imm_op = '0;
  logic [7:0]  imm8 = '0;
  logic [2:0]  dst_idx = '0;
  logic [31:0] opa = '0, opb = '0;
  logic [3:0]  flags_in = '0;
  logic        out_valid, wr_en;
  logic [31:0] result;
  logic [2:0]  wr_idx;
  logic [3:0]  flags_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  lowreg_alu u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fmt_sel(fmt_sel),
    .sub_sel(sub_sel), .imm_sel(imm_sel), .fld3(fld3), .imm_op(imm_op),
    .imm8(imm8), .dst_idx(dst_idx), .opa(opa), .opb(opb),
    .flags_in(flags_in), .out_valid(out_valid), .result(result),
    .wr_en(wr_en), .wr_idx(wr_idx), .flags_out(flags_out)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        fmt;
    logic        sub;
    logic        imm;
    logic [2:0]  f3;
    logic [1:0]  op;
    logic [7:0]  i8;
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  fi;
    logic [31:0] er;
    logic        we;
    logic [3:0]  ef;
  } vec_t;

  localparam int NV = 12;
  // flags are {N,Z,C,V}
  localparam vec_t VECS [NV] = '{
    // R2 register operand, plain add
    '{4'd2, 1'b0, 1'b0, 1'b0, 3'd3, 2'd0, 8'h00, 32'h5, 32'h3, 4'hF, 32'h8, 1'b1, 4'b0000},
    // R2 R3 immediate operand 7, opb ignored, carry out
    '{4'd3, 1'b0, 1'b0, 1'b1, 3'd7, 2'd0, 8'h00, 32'hFFFFFFFF, 32'h1234, 4'h0, 32'h6, 1'b1, 4'b0010},
    // R3 signed overflow on add
    '{4'd3, 1'b0, 1'b0, 1'b0, 3'd1, 2'd0, 8'h00, 32'h7FFFFFFF, 32'h1, 4'h0, 32'h80000000, 1'b1, 4'b1001},
    // R4 borrow: op2 > op1
    '{4'd4, 1'b0, 1'b1, 1'b0, 3'd5, 2'd0, 8'h00, 32'h3, 32'h5, 4'h0, 32'hFFFFFFFE, 1'b1, 4'b1000},
    // R4 R8 equal operands through immediate 4
    '{4'd4, 1'b0, 1'b1, 1'b1, 3'd4, 2'd0, 8'h00, 32'h4, 32'hDEADBEEF, 4'h0, 32'h0, 1'b1, 4'b0110},
    // R4 signed overflow on subtract
    '{4'd4, 1'b0, 1'b1, 1'b0, 3'd1, 2'd0, 8'h00, 32'h80000000, 32'h1, 4'h0, 32'h7FFFFFFF, 1'b1, 4'b0011},
    // R7 move keeps C=1 V=1
    '{4'd7, 1'b1, 1'b1, 1'b1, 3'd0, 2'd0, 8'h80, 32'h12345678, 32'hDEADBEEF, 4'b0011, 32'h80, 1'b1, 4'b0011},
    // R7 move of zero keeps C=1 V=0
    '{4'd7, 1'b1, 1'b0, 1'b0, 3'd0, 2'd0, 8'h00, 32'h1, 32'hDEADBEEF, 4'b1010, 32'h0, 1'b1, 4'b0110},
    // R6 compare equal
    '{4'd6, 1'b1, 1'b0, 1'b0, 3'd0, 2'd1, 8'h10, 32'h10, 32'hDEADBEEF, 4'b0000, 32'h0, 1'b0, 4'b0110},
    // R6 compare with borrow
    '{4'd6, 1'b1, 1'b0, 1'b1, 3'd0, 2'd1, 8'hFF, 32'h5, 32'hDEADBEEF, 4'b0111, 32'hFFFFFF06, 1'b0, 4'b1000},
    // R5 immediate add wrapping to zero
    '{4'd5, 1'b1, 1'b1, 1'b0, 3'd0, 2'd2, 8'h80, 32'hFFFFFF80, 32'hDEADBEEF, 4'b1001, 32'h0, 1'b1, 4'b0110},
    // R5 immediate subtract
    '{4'd5, 1'b1, 1'b0, 1'b1, 3'd0, 2'd3, 8'h01, 32'h100, 32'hDEADBEEF, 4'b1100, 32'hFF, 1'b1, 4'b0010}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 wr_en", {31'd0, wr_en}, 32'd0);
    check("R1 result", result, 32'd0);
    check("R1 flags", {28'd0, flags_out}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      @(negedge clk);
      in_valid = 1'b1; fmt_sel = v.fmt; sub_sel = v.sub; imm_sel = v.imm;
      fld3 = v.f3; imm_op = v.op; imm8 = v.i8; opa = v.a; opb = v.b;
      flags_in = v.fi; dst_idx = 3'(i);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R%0d vec%0d result", v.req, i), result, v.er);
      check($sformatf("R%0d vec%0d wr_en", v.req, i), {31'd0, wr_en}, {31'd0, v.we});
      check($sformatf("R%0d vec%0d flags", v.req, i), {28'd0, flags_out}, {28'd0, v.ef});
      check($sformatf("R8 R9 vec%0d valid", i), {31'd0, out_valid}, 32'd1);
      check($sformatf("R9 vec%0d wr_idx", i), {29'd0, wr_idx}, 32'(i % 8));
    end

    // R10 idle hold: last vector gave result FF, flags 0010, idx 3
    opa = 32'hFFFFFFFF; imm8 = 8'h00; dst_idx = 3'd6;
    @(negedge clk);
    check("R10 out_valid", {31'd0, out_valid}, 32'd0);
    check("R10 wr_en", {31'd0, wr_en}, 32'd0);
    check("R10 result", result, 32'hFF);
    check("R10 flags", {28'd0, flags_out}, 32'b0010);
    check("R10 wr_idx", {29'd0, wr_idx}, 32'd3);

    // R9 back-to-back operations, each visible one edge later
    in_valid = 1'b1; fmt_sel = 1'b0; sub_sel = 1'b0; imm_sel = 1'b1;
    fld3 = 3'd2; opa = 32'd40; dst_idx = 3'd5;
    @(negedge clk);
    check("R9 b2b first", result, 32'd42);
    sub_sel = 1'b1; fld3 = 3'd0; opa = 32'd0; dst_idx = 3'd1;
    @(negedge clk);
    check("R9 b2b second", result, 32'd0);
    check("R8 b2b zero flags", {28'd0, flags_out}, 32'b0110);
    check("R9 b2b idx", {29'd0, wr_idx}, 32'd1);

    // R1 reset in mid-stream
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset valid", {31'd0, out_valid}, 32'd0);
    check("R1 mid reset result", result, 32'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule